// File: doc/BRIEF.md
# Byte-Bus Interrupt Request and Mask Unit

This block collects up to eight interrupt requests from peripherals into a pending register. It lets software enable or disable each one through a mask, and drives a single level-sensitive interrupt line towards the CPU. Peripherals raise requests with a one-cycle post vector and withdraw them with a one-cycle clear vector. Software reaches the block over a byte-wide register bus. It writes the mask, retires one pending request by writing its index as an acknowledge, and reads the pending set back. The pending set can also be read as one 64-bit access.

The mask register holds the complement of an enable set. A written 1 blocks a request and a written 0 lets it through, and a read returns the byte as written. The CPU line is a tracked flag. It is recomputed at the same clock edge as every mask write, acknowledge, post or clear. There is no priority arbitration. A second controller is present only as a plain stored mask byte, and its pending register always reads zero.

Top module: `imc_ctrl`

## Requirements
- R1: After reset the pending set is empty, the enable set is all zeros (so the primary mask reads 0xFF), the secondary mask is 0x00, cpu_irq is low and bus_err is low.
- R2: A byte write to register 0 (primary mask) is stored as its bitwise complement in the enable set. A byte read of register 0 returns the byte last written.
- R3: cpu_irq is high exactly when some bit is set in both the pending and the enable sets. It changes at the same clock edge that applies the mask write, acknowledge, post or clear responsible for the change.
- R4: A byte write to register 1 is an acknowledge that clears the pending bit indexed by wdata[3:0]. Indices 8 to 15 clear nothing. An acknowledge beats a post of the same bit in the same cycle.
- R5: Each bit set in post_vec during a cycle sets the matching pending bit at the next edge.
- R6: Each bit set in clr_vec during a cycle clears the matching pending bit at the next edge. A clear beats a post of the same bit in the same cycle.
- R7: A read of register 1 returns the pending set in bus_rdata[7:0] with all upper bits zero, both for a byte access and for a 64-bit access. Read data appears on bus_rdata in the cycle after the request edge and is held until the next accepted read.
- R8: A byte write to register 2 (secondary mask) stores the byte unmodified, and a byte read returns it. It has no effect on cpu_irq.
- R9: A byte read of register 3 (secondary pending) returns zero. A byte write to it changes nothing.
- R10: bus_size encodes 00 = byte, 01 = 16-bit, 10 = 32-bit, 11 = 64-bit. Any access other than a byte access, or a 64-bit read of register 1, pulses bus_err high for the one cycle after its edge. Such an access changes no register and leaves bus_rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 primary mask, 1 primary pending/acknowledge, 2 secondary mask, 3 secondary pending |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 64 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after an access of an unsupported size |
| post_vec | input | 8 | Request bits to set |
| clr_vec | input | 8 | Request bits to withdraw |
| cpu_irq | output | 1 | Level interrupt towards the CPU |

## Verification
The bench aims at the inverted mask storage. A design that stored the byte directly would read back correctly but would raise cpu_irq for masked requests, so every mask write is followed by a check of the line. Acknowledge indices of 8 and above, and bytes whose upper nibble is set, are used because a design that took three bits would clear the wrong request. Simultaneous post-with-clear and post-with-acknowledge show whether a same-cycle post wrongly survives. Bad sizes are written with data that would otherwise unmask or retire requests, which exposes a design that raises the error but still commits the write.

// File: rtl/imc_pkg.sv
package imc_pkg;

  localparam int VEC_W = 8;
  localparam int IDX_W = 4;

  typedef logic [VEC_W-1:0] vec_t;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    RG_PMASK = 2'd0,
    RG_PPEND = 2'd1,
    RG_SMASK = 2'd2,
    RG_SPEND = 2'd3
  } reg_sel_e;

  // one-hot of an acknowledge index; indices past the vector select nothing
  function automatic vec_t ack_bits(input logic [IDX_W-1:0] idx);
    vec_t r;
    r = '0;
    if (idx < IDX_W'(VEC_W)) r[idx[2:0]] = 1'b1;
    return r;
  endfunction

  // clears and acknowledges both win over a same-cycle post
  function automatic vec_t pend_next(input vec_t cur, input vec_t post,
                                     input vec_t clr, input vec_t ack);
    return (cur | post) & ~clr & ~ack;
  endfunction

  function automatic logic irq_level(input vec_t pend, input vec_t en);
    return |(pend & en);
  endfunction

  function automatic logic access_ok(input logic we, input reg_sel_e sel,
                                     input acc_size_e sz);
    return (sz == SZ_BYTE) || (!we && sel == RG_PPEND && sz == SZ_DWORD);
  endfunction

endpackage

// File: rtl/imc_decode.sv
module imc_decode
  import imc_pkg::*;
(
  input  logic       bus_req,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [1:0] bus_size,
  output logic       wr_pmask,
  output logic       wr_ack,
  output logic       wr_smask,
  output logic       rd_stb,
  output logic       bad_stb,
  output reg_sel_e   sel
);

  logic ok;

  always_comb begin
    sel      = reg_sel_e'(bus_addr);
    ok       = access_ok(bus_we, sel, acc_size_e'(bus_size));
    bad_stb  = bus_req && !ok;
    rd_stb   = bus_req && ok && !bus_we;
    wr_pmask = bus_req && ok && bus_we && (sel == RG_PMASK);
    wr_ack   = bus_req && ok && bus_we && (sel == RG_PPEND);
    wr_smask = bus_req && ok && bus_we && (sel == RG_SMASK);
  end

  // R10: a faulting access never also produces an action strobe
  always_comb begin
    a_r10_strobes_exclusive: assert ($onehot0({wr_pmask, wr_ack, wr_smask, rd_stb, bad_stb}))
      else $error("decode strobes overlap");
  end

endmodule

// File: rtl/imc_pending.sv
module imc_pending
  import imc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  vec_t             post_vec,
  input  vec_t             clr_vec,
  input  logic             ack_stb,
  input  logic [IDX_W-1:0] ack_idx,
  output vec_t             pend_q,
  output vec_t             pend_d
);

  vec_t ack_vec;
  vec_t post_eff;

  always_comb begin
    ack_vec  = ack_stb ? ack_bits(ack_idx) : '0;
    post_eff = post_vec & ~clr_vec & ~ack_vec;
    pend_d   = pend_next(pend_q, post_vec, clr_vec, ack_vec);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ack_stb) && !$past(ack_idx[3])) |-> !pend_q[$past(ack_idx[2:0])])
    else $error("acknowledged bit still pending");

  a_r5_post_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(post_eff)) == $past(post_eff)))
    else $error("posted bit not pending");

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(clr_vec)) == '0))
    else $error("cleared bit still pending");

endmodule

// File: rtl/imc_mask.sv
module imc_mask
  import imc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_pmask,
  input  logic wr_smask,
  input  vec_t wdata,
  output vec_t en_q,
  output vec_t en_d,
  output vec_t smask_q
);

  always_comb en_d = wr_pmask ? ~wdata : en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      smask_q <= '0;
    end else begin
      en_q <= en_d;
      if (wr_smask) smask_q <= wdata;
    end
  end

  a_r2_enable_is_complement: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_pmask) |-> (en_q == ~$past(wdata)))
    else $error("enable not complement of written mask");

  a_r8_smask_plain: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_smask) |-> (smask_q == $past(wdata)))
    else $error("secondary mask altered");

endmodule

// File: rtl/imc_irq.sv
module imc_irq
  import imc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  vec_t pend_d,
  input  vec_t en_d,
  output logic irq_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)   irq_q <= 1'b0;
    else if (evt) irq_q <= irq_level(pend_d, en_d);
  end

  a_r3_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(evt) |-> $stable(irq_q))
    else $error("irq moved without an event");

endmodule

// File: rtl/imc_ctrl.sv
module imc_ctrl
  import imc_pkg::*;
#(
  parameter int RD_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_req,
  input  logic            bus_we,
  input  logic [1:0]      bus_addr,
  input  logic [1:0]      bus_size,
  input  logic [7:0]      bus_wdata,
  output logic [RD_W-1:0] bus_rdata,
  output logic            bus_err,
  input  logic [7:0]      post_vec,
  input  logic [7:0]      clr_vec,
  output logic            cpu_irq
);

  localparam int PAD_W = RD_W - VEC_W;

  logic     wr_pmask, wr_ack, wr_smask, rd_stb, bad_stb;
  reg_sel_e sel;
  vec_t     pend_q, pend_d, en_q, en_d, smask_q;
  logic     evt;
  vec_t     rd_byte;

  imc_decode u_dec (
    .bus_req (bus_req),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .bus_size(bus_size),
    .wr_pmask(wr_pmask),
    .wr_ack  (wr_ack),
    .wr_smask(wr_smask),
    .rd_stb  (rd_stb),
    .bad_stb (bad_stb),
    .sel     (sel)
  );

  imc_pending u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .post_vec(post_vec),
    .clr_vec (clr_vec),
    .ack_stb (wr_ack),
    .ack_idx (bus_wdata[IDX_W-1:0]),
    .pend_q  (pend_q),
    .pend_d  (pend_d)
  );

  imc_mask u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_pmask(wr_pmask),
    .wr_smask(wr_smask),
    .wdata   (bus_wdata),
    .en_q    (en_q),
    .en_d    (en_d),
    .smask_q (smask_q)
  );

  assign evt = wr_pmask || wr_ack || (|post_vec) || (|clr_vec);

  imc_irq u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt),
    .pend_d(pend_d),
    .en_d  (en_d),
    .irq_q (cpu_irq)
  );

  always_comb begin
    unique case (sel)
      RG_PMASK: rd_byte = ~en_q;
      RG_PPEND: rd_byte = pend_q;
      RG_SMASK: rd_byte = smask_q;
      default:  rd_byte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err <= bad_stb;
      if (rd_stb) bus_rdata <= {{PAD_W{1'b0}}, rd_byte};
    end
  end

  a_r3_irq_tracks_masked_pending: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == irq_level(pend_q, en_q))
    else $error("cpu_irq out of step with pending and enable");

  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[RD_W-1:VEC_W] == '0)
    else $error("read data upper bits not zero");

  a_r10_bad_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bad_stb) |-> (bus_err && en_q == $past(en_q) && smask_q == $past(smask_q)
                        && $stable(bus_rdata)))
    else $error("faulting access changed state");

endmodule

// File: tb/imc_ctrl_tb.sv
module imc_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0, bus_size = '0;
  logic [7:0]  bus_wdata = '0, post_vec = '0, clr_vec = '0;
  logic [63:0] bus_rdata;
  logic        bus_err, cpu_irq;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  imc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .post_vec(post_vec),
    .clr_vec(clr_vec), .cpu_irq(cpu_irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic we, input logic [1:0] a, input logic [1:0] sz,
                        input logic [7:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic vec_op(input logic [7:0] p, input logic [7:0] c);
    @(negedge clk);
    post_vec = p; clr_vec = c;
    @(negedge clk);
    post_vec = '0; clr_vec = '0;
  endtask

  task automatic rd(input logic [1:0] a, input string tag, input logic [63:0] exp);
    bus_op(1'b0, a, 2'b00, 8'h00);
    check(tag, bus_rdata, exp);
  endtask

  task automatic t_reset;
    check("R1 irq", {63'd0, cpu_irq}, 64'd0);
    check("R1 err", {63'd0, bus_err}, 64'd0);
    rd(2'd0, "R1 mask", 64'hFF);
    rd(2'd1, "R1 pending", 64'h0);
    rd(2'd2, "R1 smask", 64'h0);
  endtask

  task automatic t_mask_irq;
    bus_op(1'b1, 2'd0, 2'b00, 8'hA5);
    rd(2'd0, "R2 mask readback", 64'hA5);
    vec_op(8'h5A, 8'h00);
    check("R3 irq after post", {63'd0, cpu_irq}, 64'd1);
    rd(2'd1, "R5 pending after post", 64'h5A);
    bus_op(1'b1, 2'd0, 2'b00, 8'hFF);
    check("R3 irq all masked", {63'd0, cpu_irq}, 64'd0);
    bus_op(1'b1, 2'd0, 2'b00, 8'hF7);
    check("R2 R3 irq bit3 enabled", {63'd0, cpu_irq}, 64'd1);
  endtask

  task automatic t_ack;
    bus_op(1'b1, 2'd1, 2'b00, 8'h03);
    check("R4 R3 irq after ack", {63'd0, cpu_irq}, 64'd0);
    rd(2'd1, "R4 ack idx3", 64'h52);
    bus_op(1'b1, 2'd1, 2'b00, 8'h09);
    rd(2'd1, "R4 ack idx9 no effect", 64'h52);
    bus_op(1'b1, 2'd1, 2'b00, 8'hF1);
    rd(2'd1, "R4 upper nibble ignored", 64'h50);
    // acknowledge bit 2 while posting bits 2 and 0 in the same cycle
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 2'd1; bus_size = 2'b00; bus_wdata = 8'h02;
    post_vec = 8'h05;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; post_vec = '0;
    rd(2'd1, "R4 ack beats post", 64'h51);
  endtask

  task automatic t_clear;
    vec_op(8'h00, 8'h10);
    rd(2'd1, "R6 clear", 64'h41);
    vec_op(8'h0A, 8'h02);
    rd(2'd1, "R6 clear beats post", 64'h49);
    check("R3 irq bit3 via post", {63'd0, cpu_irq}, 64'd1);
    vec_op(8'h00, 8'h08);
    check("R3 irq dropped by clear", {63'd0, cpu_irq}, 64'd0);
  endtask

  task automatic t_read64;
    bus_op(1'b0, 2'd1, 2'b11, 8'h00);
    check("R7 64-bit read", bus_rdata, 64'h41);
    check("R10 no err on 64-bit read", {63'd0, bus_err}, 64'd0);
  endtask

  task automatic t_secondary;
    bus_op(1'b1, 2'd2, 2'b00, 8'h3C);
    rd(2'd2, "R8 smask readback", 64'h3C);
    check("R8 irq unchanged", {63'd0, cpu_irq}, 64'd0);
    bus_op(1'b1, 2'd3, 2'b00, 8'hFF);
    rd(2'd3, "R9 spend reads zero", 64'h0);
    rd(2'd1, "R9 pending untouched", 64'h41);
    rd(2'd0, "R9 mask untouched", 64'hF7);
  endtask

  task automatic t_illegal;
    rd(2'd0, "R10 prime", 64'hF7);
    bus_op(1'b1, 2'd0, 2'b01, 8'h00);
    check("R10 err half write", {63'd0, bus_err}, 64'd1);
    @(negedge clk);
    check("R10 err one cycle", {63'd0, bus_err}, 64'd0);
    check("R10 irq unchanged", {63'd0, cpu_irq}, 64'd0);
    bus_op(1'b0, 2'd0, 2'b10, 8'h00);
    check("R10 err word read", {63'd0, bus_err}, 64'd1);
    check("R10 rdata held", bus_rdata, 64'hF7);
    bus_op(1'b1, 2'd1, 2'b11, 8'h06);
    check("R10 err dword write", {63'd0, bus_err}, 64'd1);
    rd(2'd1, "R10 pending untouched", 64'h41);
    rd(2'd0, "R10 mask untouched", 64'hF7);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mask_irq();
    t_ack();
    t_clear();
    t_read64();
    t_secondary();
    t_illegal();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule